// File: doc/BRIEF.md
# Prioritized Address Window Remapper

This block sits between a processor's physical address output and the system interconnect. It holds a small set of address windows. Each window has a base register, a mask register and a mapping register, and all of them are loaded over a simple one-cycle register-write port. For every request, the block looks for the lowest-numbered window that is enabled and matches the address. The address bits that the mask selects are then replaced by the same bits of the mapping register, and the remaining address bits pass through unchanged.

Alongside the translated address, the block reports the destination port of the winning window (one of four), its burst/cacheable attribute and its instruction-fetch permission. It also raises a miss flag when no window claims the address, and a fetch-denied flag when an instruction fetch lands in a window that does not permit fetches. The lookup is purely combinational. Configuration writes take effect at the clock edge that samples the write strobe. A typical setup uses the last window as a catch-all, with a zero base and a zero mask, placed below the more specific windows.

Top module: `addr_window_remap`

## Requirements
- R1: After a synchronous reset every window is disabled, so every request reports a miss until a mapping register is written.
- R2: A window hits when bit 7 of its mapping register is set and (address AND mask) equals (base AND mask). A window with bit 7 clear never hits, even if its base and mask would match.
- R3: On a hit, the translated address is (request AND NOT mask) OR (mapping AND mask), using the winning window's registers.
- R4: When several windows hit, the lowest-numbered one wins.
- R5: Mapping register fields of the winning window: bits 1:0 give the destination, bit 5 gives the burst/cacheable output and bit 4 gives the fetch-permit output.
- R6: Register offsets on the configuration port are decoded as follows. Bits 7:6 select the bank (0 base, 1 mask, 2 mapping) and bits 5:3 select the window. A write with bit 2 set (upper word) or with bank 3 changes nothing.
- R7: Outputs follow the request combinationally. A configuration write becomes visible only after the clock edge that samples the write strobe.
- R8: On a miss, the miss flag is 1, the destination is 0, burst, fetch-permit and fetch-denied are 0, and the request address passes through unchanged.
- R9: An instruction-fetch request that hits a window whose fetch bit is clear raises fetch-denied. The translated address is still driven.
- R10: A window with zero base and zero mask matches every address and passes the address through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_addr | input | 32 | Physical address of the request |
| req_ifetch | input | 1 | Request is an instruction fetch |
| xl_addr | output | 32 | Translated address |
| xl_dest | output | 2 | Destination port of the winning window |
| xl_burst | output | 1 | Burst/cacheable attribute |
| xl_fetch_ok | output | 1 | Instruction fetch permitted in the winning window |
| xl_miss | output | 1 | No enabled window matched |
| xl_fetch_denied | output | 1 | Fetch request hit a non-fetchable window |

## Verification
A wrong base, mask or mapping register shows up at the ports as soon as a request falls in the affected window. It appears as a wrong translated address, destination or attribute, or as a spurious miss. Because the lookup is combinational, it appears in the same cycle the address is driven. A write that lands in the wrong bank or window, or a write to an upper word that is wrongly stored, also shows up on the first request that touches the corrupted window after the write edge. The bench therefore revisits overlapping windows after every configuration change, and it compares every output against a behavioural model on each request.

// File: rtl/awr_pkg.sv
package awr_pkg;

    localparam int unsigned AWR_WINDOWS_DEF = 8;
    localparam int unsigned AWR_ADDR_W_DEF  = 32;

    localparam int unsigned MAP_EN_BIT    = 7;
    localparam int unsigned MAP_BURST_BIT = 5;
    localparam int unsigned MAP_FETCH_BIT = 4;

    typedef enum logic [1:0] {
        BANK_BASE = 2'd0,
        BANK_MASK = 2'd1,
        BANK_MAP  = 2'd2,
        BANK_NONE = 2'd3
    } cfg_bank_e;

    typedef struct packed {
        logic       en;
        logic       burst;
        logic       fetch;
        logic [1:0] dest;
    } win_attr_t;

    function automatic win_attr_t unpack_attr(input logic [7:0] lo);
        win_attr_t a;
        a.en    = lo[MAP_EN_BIT];
        a.burst = lo[MAP_BURST_BIT];
        a.fetch = lo[MAP_FETCH_BIT];
        a.dest  = lo[1:0];
        return a;
    endfunction

endpackage

// File: rtl/awr_regs.sv
module awr_regs
    import awr_pkg::*;
#(
    parameter int unsigned NUM_WIN = AWR_WINDOWS_DEF,
    parameter int unsigned ADDR_W  = AWR_ADDR_W_DEF,
    parameter int unsigned CFG_AW  = $clog2(NUM_WIN) + 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] base_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] mask_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] map_o
);
    localparam int unsigned WIN_BITS = $clog2(NUM_WIN);

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q, mask_q, map_q;
    cfg_bank_e                      bank;
    logic [WIN_BITS-1:0]            idx;
    logic                           upper;
    logic                           wr_map;

    assign bank   = cfg_bank_e'(cfg_addr[CFG_AW-1 -: 2]);
    assign idx    = cfg_addr[3 +: WIN_BITS];
    assign upper  = cfg_addr[2];
    assign wr_map = cfg_we && !upper && (bank == BANK_MAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mask_q <= '0;
            map_q  <= '0;
        end else if (cfg_we && !upper) begin
            case (bank)
                BANK_BASE: base_q[idx] <= cfg_wdata;
                BANK_MASK: mask_q[idx] <= cfg_wdata;
                BANK_MAP:  map_q[idx]  <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    assign base_o = base_q;
    assign mask_o = mask_q;
    assign map_o  = map_q;

    // R1: the cycle after reset, no window is enabled
    a_r1_reset_disabled: assert property (@(posedge clk)
        $past(rst) |-> (map_q == '0));

    // R7: a mapping write is visible after the sampling edge
    a_r7_map_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_map)) |-> (map_q[$past(idx)] == $past(cfg_wdata)));

    // R6: writes to upper words leave every register unchanged
    a_r6_upper_ignored: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we && upper)) |->
        ($stable(base_q) && $stable(mask_q) && $stable(map_q)));

endmodule

// File: rtl/awr_match.sv
module awr_match
    import awr_pkg::*;
#(
    parameter int unsigned NUM_WIN = AWR_WINDOWS_DEF,
    parameter int unsigned ADDR_W  = AWR_ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] base_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] mask_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] map_i,
    output logic [NUM_WIN-1:0]             hit_o
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        win_attr_t attr;
        logic      tag_eq;
        assign attr       = unpack_attr(map_i[w][7:0]);
        assign tag_eq     = ((req_addr & mask_i[w]) == (base_i[w] & mask_i[w]));
        assign hit_o[w]   = attr.en && tag_eq;
    end
endmodule

// File: rtl/awr_prio.sv
module awr_prio #(
    parameter int unsigned NUM_WIN  = 8,
    parameter int unsigned WIN_BITS = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0]  hit_i,
    output logic [WIN_BITS-1:0] sel_o,
    output logic                any_o
);
    always_comb begin
        sel_o = '0;
        any_o = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                sel_o = WIN_BITS'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addr_window_remap.sv
module addr_window_remap
    import awr_pkg::*;
#(
    parameter int unsigned NUM_WIN = AWR_WINDOWS_DEF,
    parameter int unsigned ADDR_W  = AWR_ADDR_W_DEF,
    parameter int unsigned CFG_AW  = $clog2(NUM_WIN) + 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ifetch,
    output logic [ADDR_W-1:0] xl_addr,
    output logic [1:0]        xl_dest,
    output logic              xl_burst,
    output logic              xl_fetch_ok,
    output logic              xl_miss,
    output logic              xl_fetch_denied
);
    localparam int unsigned WIN_BITS = $clog2(NUM_WIN);

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_w, mask_w, map_w;
    logic [NUM_WIN-1:0]             hit;
    logic [WIN_BITS-1:0]            sel;
    logic                           any_hit;
    win_attr_t                      attr;
    logic [ADDR_W-1:0]              sel_mask, sel_map;

    awr_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_o(base_w), .mask_o(mask_w), .map_o(map_w)
    );

    awr_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_match (
        .req_addr(req_addr), .base_i(base_w), .mask_i(mask_w),
        .map_i(map_w), .hit_o(hit)
    );

    awr_prio #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)) u_prio (
        .hit_i(hit), .sel_o(sel), .any_o(any_hit)
    );

    assign sel_mask = mask_w[sel];
    assign sel_map  = map_w[sel];
    assign attr     = unpack_attr(sel_map[7:0]);

    always_comb begin
        if (any_hit) begin
            xl_addr     = (req_addr & ~sel_mask) | (sel_map & sel_mask);
            xl_dest     = attr.dest;
            xl_burst    = attr.burst;
            xl_fetch_ok = attr.fetch;
        end else begin
            xl_addr     = req_addr;
            xl_dest     = 2'd0;
            xl_burst    = 1'b0;
            xl_fetch_ok = 1'b0;
        end
    end

    assign xl_miss         = !any_hit;
    assign xl_fetch_denied = any_hit && req_ifetch && !attr.fetch;

    // R8: a miss drives neutral attributes and passes the address
    a_r8_miss_neutral: assert property (@(posedge clk) disable iff (rst)
        xl_miss |-> (xl_dest == 2'd0 && !xl_burst && !xl_fetch_ok &&
                     !xl_fetch_denied && xl_addr == req_addr));

    // R4: the winner is a hitting window and no lower window hits
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        !xl_miss |-> (hit[sel] && ((hit & ((NUM_WIN'(1) << sel) - NUM_WIN'(1))) == '0)));

    // R9: fetch-denied only for fetch requests that hit
    a_r9_denied_cause: assert property (@(posedge clk) disable iff (rst)
        xl_fetch_denied |-> (req_ifetch && !xl_miss && !xl_fetch_ok));

    // R3: unmasked bits of the request survive translation
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
        !xl_miss |-> ((xl_addr & ~sel_mask) == (req_addr & ~sel_mask)));

endmodule

// File: tb/addr_window_remap_tb.sv
module addr_window_remap_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] req_addr = '0;
    logic        req_ifetch = 1'b0;
    logic [31:0] xl_addr;
    logic [1:0]  xl_dest;
    logic        xl_burst, xl_fetch_ok, xl_miss, xl_fetch_denied;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_mask [8];
    logic [31:0] m_map  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_remap u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_addr(req_addr), .req_ifetch(req_ifetch),
        .xl_addr(xl_addr), .xl_dest(xl_dest), .xl_burst(xl_burst),
        .xl_fetch_ok(xl_fetch_ok), .xl_miss(xl_miss),
        .xl_fetch_denied(xl_fetch_denied)
    );

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_map[i] = '0;
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int idx;
        idx = int'(a[5:3]);
        if (!a[2]) begin
            case (a[7:6])
                2'd0: m_base[idx] = d;
                2'd1: m_mask[idx] = d;
                2'd2: m_map[idx]  = d;
                default: ;
            endcase
        end
    endtask

    // Full comparison of every output against the behavioural model
    task automatic compare(input string tag);
        int w;
        logic [31:0] ea;
        logic [1:0]  ed;
        logic        eb, efo, em, efd;
        w = -1;
        for (int i = 0; i < 8; i++)
            if (w < 0 && m_map[i][7] &&
                ((req_addr & m_mask[i]) == (m_base[i] & m_mask[i])))
                w = i;
        if (w < 0) begin
            ea = req_addr; ed = 2'd0; eb = 0; efo = 0; em = 1; efd = 0;
        end else begin
            ea  = (req_addr & ~m_mask[w]) | (m_map[w] & m_mask[w]);
            ed  = m_map[w][1:0];
            eb  = m_map[w][5];
            efo = m_map[w][4];
            em  = 0;
            efd = req_ifetch && !m_map[w][4];
        end
        n_checks++;
        if (xl_addr !== ea || xl_dest !== ed || xl_burst !== eb ||
            xl_fetch_ok !== efo || xl_miss !== em || xl_fetch_denied !== efd) begin
            n_fail++;
            $display("FAIL %s req=%h: got addr=%h dest=%0d b=%0b f=%0b m=%0b d=%0b exp addr=%h dest=%0d b=%0b f=%0b m=%0b d=%0b",
                     tag, req_addr, xl_addr, xl_dest, xl_burst, xl_fetch_ok, xl_miss,
                     xl_fetch_denied, ea, ed, eb, efo, em, efd);
        end
    endtask

    task automatic expect_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        model_write(a, d);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [31:0] a, input logic f, input string tag);
        @(negedge clk);
        req_addr = a; req_ifetch = f;
        #1;
        compare(tag);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything disabled after reset
        drive(32'h1fc0_0000, 0, "R1");
        expect_val("R1 miss", {31'd0, xl_miss}, 32'd1);
        drive(32'h0000_0000, 1, "R1");
        drive(32'hffff_ffff, 0, "R1");
        expect_val("R1 addr", xl_addr, 32'hffff_ffff);

        // Window 3: 1 MB, remapped, burst, dest 1, no fetch
        cfg_write(8'h18, 32'h1fc0_0000);
        cfg_write(8'h58, 32'hfff0_0000);
        // R7: write not visible before the sampling edge
        @(negedge clk);
        req_addr = 32'h1fc1_2345; req_ifetch = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h98; cfg_wdata = 32'h2a00_00a1;
        #1;
        compare("R7 before edge");
        expect_val("R7 still miss", {31'd0, xl_miss}, 32'd1);
        @(posedge clk);
        #1;
        model_write(8'h98, 32'h2a00_00a1);
        cfg_we = 1'b0;
        compare("R7 after edge");

        drive(32'h1fc1_2345, 0, "R3");
        expect_val("R3 addr", xl_addr, 32'h2a01_2345);
        expect_val("R5 dest", {30'd0, xl_dest}, 32'd1);
        expect_val("R5 burst", {31'd0, xl_burst}, 32'd1);
        expect_val("R5 fetch", {31'd0, xl_fetch_ok}, 32'd0);
        drive(32'h1fc1_2345, 1, "R9");
        expect_val("R9 denied", {31'd0, xl_fetch_denied}, 32'd1);
        expect_val("R9 addr kept", xl_addr, 32'h2a01_2345);
        drive(32'h1fd0_0000, 1, "R8");
        expect_val("R8 miss", {31'd0, xl_miss}, 32'd1);
        expect_val("R8 denied low", {31'd0, xl_fetch_denied}, 32'd0);

        // R6: upper-word and bank-3 writes have no effect
        cfg_write(8'h9c, 32'h0000_0000);
        cfg_write(8'h1c, 32'hffff_ffff);
        cfg_write(8'hd8, 32'h0000_0000);
        drive(32'h1fc1_2345, 0, "R6");
        expect_val("R6 addr", xl_addr, 32'h2a01_2345);

        // Window 1 overlaps window 3: lower index wins
        cfg_write(8'h08, 32'h1f00_0000);
        cfg_write(8'h48, 32'hff00_0000);
        cfg_write(8'h88, 32'h5000_00d2);
        drive(32'h1fc1_2345, 1, "R4");
        expect_val("R4 addr", xl_addr, 32'h50c1_2345);
        expect_val("R4 dest", {30'd0, xl_dest}, 32'd2);
        expect_val("R4 denied", {31'd0, xl_fetch_denied}, 32'd0);

        // R2: disabling window 1 exposes window 3 again
        cfg_write(8'h88, 32'h5000_0052);
        drive(32'h1fc1_2345, 0, "R2");
        expect_val("R2 addr", xl_addr, 32'h2a01_2345);
        drive(32'h1f00_0010, 0, "R2");
        expect_val("R2 miss", {31'd0, xl_miss}, 32'd1);

        // R10: catch-all window 7
        cfg_write(8'h38, 32'h0000_0000);
        cfg_write(8'h78, 32'h0000_0000);
        cfg_write(8'hb8, 32'h0000_00f0);
        drive(32'h1234_5678, 1, "R10");
        expect_val("R10 addr", xl_addr, 32'h1234_5678);
        expect_val("R10 miss", {31'd0, xl_miss}, 32'd0);
        expect_val("R10 burst", {31'd0, xl_burst}, 32'd1);
        drive(32'h1fc0_0000, 0, "R4");
        expect_val("R4 over catch-all", xl_addr, 32'h2a00_0000);

        // Sweep against the model, mixing windowed and unwindowed addresses
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            a = $urandom;
            if (k % 3 == 0) a = {12'h1fc, a[19:0]};
            if (k % 3 == 1) a = {8'h1f, a[23:0]};
            drive(a, a[0], "R3");
            if (k == 150) begin
                cfg_write(8'hb8, 32'h0000_0000);
                cfg_write(8'h88, 32'h7700_00f3);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule